// File: doc/BRIEF.md
# FPGA Configuration Loader

This block loads one or more FPGAs from an attached flash device. After reset it fetches a 32-word block of option settings from a fixed flash location. Those settings fix the output format, the configuration clock rate and where each stored image sits in flash. The page select pins are captured during reset and pick one of eight images. The loader then waits for the target to report that it is ready. Once it is, it streams the chosen image out on a generated configuration clock and an 8-line data bus.

Three output formats exist: a single serial chain, several serial chains driven side by side, and a byte-wide bus. Each one takes successive bits from every flash word, least significant first. The loader watches the target's status line while it streams. A fault restarts the image from its first word, and a completion indication from the target ends the transfer early.

Top module: `cfg_loader`

## Requirements
- R1: After reset the loader's first 32 flash reads are at word addresses 0x8000 through 0x801F, in increasing order, and no configuration clock pulse occurs before all 32 have been returned.
- R2: Option word 0 holds the format in bits [1:0] (0 single chain, 1 multi-chain, 2 byte-wide), the clock divider in bits [7:4] and the chain count minus one in bits [10:8]. For page p, option word 2+2p holds the image start address and option word 3+2p holds its length in words.
- R3: pgmSel is captured only while rstN is low. Changing it after reset has no effect on which image is streamed.
- R4: The configuration clock stays low and no transfer starts unless nStatus is high and confDone is low.
- R5: In single-chain format each word is sent LSB first on cfgData[0], one bit per clock pulse (16 pulses per word), with cfgData[7:1] at 0.
- R6: In multi-chain format with n chains, each clock pulse carries the next n bits of the word, with the lowest of them on cfgData[0]. Lines n and above stay 0, and the last slice of a word is padded with zeros.
- R7: In byte-wide format each word gives two clock pulses: bits [7:0] first, then bits [15:8].
- R8: Each configuration clock high phase lasts exactly divider system clock cycles, where a divider of 0 acts as 1. cfgData changes only while the clock is low.
- R9: Image words are fetched at start, start+1, and so on. A flash request is held with a stable address until flashValid, and the clock stays low while a word is awaited.
- R10: After the last word of the image (or at once for a length of 0), loadDone rises and stays high, and the clock stays low.
- R11: confDone rising during a transfer stops it: loadDone rises and no further clock pulses occur.
- R12: nStatus falling during a transfer sets cfgErr, which stays set until reset, clears cfgData and restarts the image from its first word once the target is ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| pgmSel | input | 3 | Image page select, captured during reset |
| nStatus | input | 1 | Target status, high when healthy |
| confDone | input | 1 | Target reports configuration complete |
| flashReq | output | 1 | Flash read request, held until flashValid |
| flashAddr | output | 16 | Flash word address |
| flashValid | input | 1 | Flash read data valid (one cycle) |
| flashData | input | 16 | Flash read data |
| dclk | output | 1 | Configuration clock |
| cfgData | output | 8 | Configuration data lines |
| loadDone | output | 1 | Transfer finished or stopped by target |
| cfgErr | output | 1 | Sticky fault flag |

## Verification
A word accepted on flashValid appears on cfgData at the next clock edge. The first clock rise follows divider cycles later, and each further slice appears at the edge that ends a high phase. The bench therefore compares data only on the observed rising edges of dclk, sampled at the falling system clock edge, and not at any computed cycle number. Fault and stop reactions take effect one system clock edge after the input changes, so those checks wait two falling edges before looking. The wait states are checked over a window of twenty cycles with no clock rise.

// File: rtl/cfg_loader_pkg.sv
`timescale 1ns / 1ps
package cfg_loader_pkg;

  typedef enum logic [1:0] {
    MODE_SERIAL = 2'd0,
    MODE_MULTI  = 2'd1,
    MODE_BYTE   = 2'd2,
    MODE_RSVD   = 2'd3
  } outMode_e;

  typedef enum logic [2:0] {
    ST_OPTS  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_FETCH = 3'd2,
    ST_LOW   = 3'd3,
    ST_HIGH  = 3'd4,
    ST_DONE  = 3'd5
  } ldState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWord;
    logic shiftSlice;
    logic clrData;
  } dpCmd_t;

endpackage

// File: rtl/cfg_loader_dp.sv
`timescale 1ns / 1ps
module cfg_loader_dp
  import cfg_loader_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OUT_W  = 8,
  localparam int SLICE_W = $clog2(OUT_W) + 1,
  localparam int CNT_W   = $clog2(WORD_W) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCmd_t             cmd,
  input  logic [SLICE_W-1:0] sliceW,
  input  logic [WORD_W-1:0]  flashData,
  output logic [OUT_W-1:0]   cfgData,
  output logic               sliceEmpty
);

  logic [WORD_W-1:0] shReg;
  logic [CNT_W-1:0]  bitsLeft;
  logic [OUT_W-1:0]  dataOut;
  logic [OUT_W-1:0]  sliceMask;

  // one enable per output line: line g carries data only below the slice width
  for (genvar g = 0; g < OUT_W; g++) begin : g_mask
    assign sliceMask[g] = (SLICE_W'(g) < sliceW);
  end

  logic [WORD_W-1:0] srcWord;
  logic [CNT_W-1:0]  srcBits;
  logic [CNT_W-1:0]  stepBits;

  assign srcWord  = cmd.loadWord ? flashData : shReg;
  assign srcBits  = cmd.loadWord ? CNT_W'(WORD_W) : bitsLeft;
  assign stepBits = CNT_W'(sliceW);

  always_ff @(posedge clk) begin
    if (!rstN || cmd.clrData) begin
      shReg    <= '0;
      bitsLeft <= '0;
      dataOut  <= '0;
    end else if (cmd.loadWord || cmd.shiftSlice) begin
      dataOut  <= srcWord[OUT_W-1:0] & sliceMask;
      shReg    <= srcWord >> sliceW;
      bitsLeft <= (srcBits > stepBits) ? srcBits - stepBits : '0;
    end
  end

  assign cfgData    = dataOut;
  assign sliceEmpty = (bitsLeft == '0);

  // R6 / R5: lines above the active chain count never carry data
  a_r6_unused_lines_low: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.loadWord || cmd.shiftSlice) |=> ((dataOut & ~sliceMask) == '0));

endmodule

// File: rtl/cfg_loader_ctrl.sv
`timescale 1ns / 1ps
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WORD_W    = 16,
  parameter int OUT_W     = 8,
  parameter int DIV_W     = 4,
  parameter int PAGES     = 8,
  parameter int OPT_WORDS = 32,
  parameter logic [ADDR_W-1:0] OPT_BASE = 16'h8000,
  localparam int PAGE_W    = $clog2(PAGES),
  localparam int OPT_IDX_W = $clog2(OPT_WORDS),
  localparam int SLICE_W   = $clog2(OUT_W) + 1,
  localparam int CHAIN_W   = $clog2(OUT_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PAGE_W-1:0]  pgmSel,
  input  logic               nStatus,
  input  logic               confDone,
  input  logic               flashValid,
  input  logic [WORD_W-1:0]  flashData,
  input  logic               sliceEmpty,
  output logic               flashReq,
  output logic [ADDR_W-1:0]  flashAddr,
  output logic               dclk,
  output logic               loadDone,
  output logic               cfgErr,
  output dpCmd_t             cmd,
  output logic [SLICE_W-1:0] sliceW
);

  // option word 0 field positions (R2)
  localparam int DIV_LSB   = 4;
  localparam int CHAIN_LSB = 8;

  ldState_e              state;
  logic [OPT_IDX_W-1:0]  optIdx;
  logic [PAGE_W-1:0]     pageReg;
  outMode_e              modeReg;
  logic [DIV_W-1:0]      divReg;
  logic [CHAIN_W-1:0]    chainReg;
  logic [ADDR_W-1:0]     startReg;
  logic [WORD_W-1:0]     lenReg;
  logic [WORD_W-1:0]     wordIdx;
  logic [DIV_W-1:0]      phaseCnt;
  logic                  errR;

  logic [DIV_W-1:0]     divEff;
  logic                 ready;
  logic                 streaming;
  logic                 phaseEnd;
  logic                 lastWord;
  logic [OPT_IDX_W-1:0] startIdx;

  assign divEff    = (divReg == '0) ? DIV_W'(1) : divReg;
  assign ready     = nStatus && !confDone;
  assign streaming = (state == ST_FETCH) || (state == ST_LOW) || (state == ST_HIGH);
  assign phaseEnd  = (phaseCnt == divEff - DIV_W'(1));
  assign lastWord  = (wordIdx == lenReg - WORD_W'(1));
  assign startIdx  = OPT_IDX_W'({pageReg, 1'b0}) + OPT_IDX_W'(2);

  assign flashReq  = (state == ST_OPTS) || (state == ST_FETCH);
  assign flashAddr = (state == ST_OPTS) ? OPT_BASE + ADDR_W'(optIdx)
                                        : startReg + ADDR_W'(wordIdx);
  assign dclk      = (state == ST_HIGH);
  assign loadDone  = (state == ST_DONE);
  assign cfgErr    = errR;

  always_comb begin
    cmd            = '0;
    cmd.loadWord   = (state == ST_FETCH) && flashValid && ready;
    cmd.shiftSlice = (state == ST_HIGH) && ready && phaseEnd && !sliceEmpty;
    cmd.clrData    = streaming && !nStatus;
  end

  always_comb begin
    case (modeReg)
      MODE_MULTI: sliceW = SLICE_W'(chainReg) + SLICE_W'(1);
      MODE_BYTE:  sliceW = SLICE_W'(OUT_W);
      default:    sliceW = SLICE_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_OPTS;
      optIdx   <= '0;
      pageReg  <= pgmSel;
      modeReg  <= MODE_SERIAL;
      divReg   <= '0;
      chainReg <= '0;
      startReg <= '0;
      lenReg   <= '0;
      wordIdx  <= '0;
      phaseCnt <= '0;
      errR     <= 1'b0;
    end else if (streaming && !nStatus) begin
      errR     <= 1'b1;
      state    <= ST_WAIT;
      phaseCnt <= '0;
    end else if (streaming && confDone) begin
      state <= ST_DONE;
    end else begin
      case (state)
        ST_OPTS: if (flashValid) begin
          if (optIdx == '0) begin
            modeReg  <= outMode_e'(flashData[1:0]);
            divReg   <= flashData[DIV_LSB +: DIV_W];
            chainReg <= flashData[CHAIN_LSB +: CHAIN_W];
          end
          if (optIdx == startIdx)                  startReg <= ADDR_W'(flashData);
          if (optIdx == startIdx + OPT_IDX_W'(1))  lenReg   <= flashData;
          if (optIdx == OPT_IDX_W'(OPT_WORDS - 1)) state    <= ST_WAIT;
          else                                     optIdx   <= optIdx + OPT_IDX_W'(1);
        end
        ST_WAIT: if (ready) begin
          wordIdx <= '0;
          state   <= (lenReg == '0) ? ST_DONE : ST_FETCH;
        end
        ST_FETCH: if (flashValid) begin
          state    <= ST_LOW;
          phaseCnt <= '0;
        end
        ST_LOW: begin
          if (phaseEnd) begin
            state    <= ST_HIGH;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + DIV_W'(1);
          end
        end
        ST_HIGH: begin
          if (phaseEnd) begin
            phaseCnt <= '0;
            if (!sliceEmpty)   state <= ST_LOW;
            else if (lastWord) state <= ST_DONE;
            else begin
              wordIdx <= wordIdx + WORD_W'(1);
              state   <= ST_FETCH;
            end
          end else begin
            phaseCnt <= phaseCnt + DIV_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  // R9: an unanswered request keeps its address while the target stays ready
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (flashReq && !flashValid && nStatus && !confDone) |=> (flashReq && $stable(flashAddr)));

  // R4: a clock rise only follows a cycle in which the target was ready
  a_r4_rise_needs_ready: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dclk) |-> $past(nStatus && !confDone));

  // R12: the fault flag never clears outside reset
  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);

  // R10 / R11: completion holds and the clock stays low afterwards
  a_r10_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> (loadDone && !dclk));

endmodule

// File: rtl/cfg_loader.sv
`timescale 1ns / 1ps
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WORD_W    = 16,
  parameter int OUT_W     = 8,
  parameter int DIV_W     = 4,
  parameter int PAGES     = 8,
  parameter int OPT_WORDS = 32,
  parameter logic [ADDR_W-1:0] OPT_BASE = 16'h8000,
  localparam int PAGE_W  = $clog2(PAGES),
  localparam int SLICE_W = $clog2(OUT_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PAGE_W-1:0] pgmSel,
  input  logic              nStatus,
  input  logic              confDone,
  output logic              flashReq,
  output logic [ADDR_W-1:0] flashAddr,
  input  logic              flashValid,
  input  logic [WORD_W-1:0] flashData,
  output logic              dclk,
  output logic [OUT_W-1:0]  cfgData,
  output logic              loadDone,
  output logic              cfgErr
);

  dpCmd_t             cmd;
  logic [SLICE_W-1:0] sliceW;
  logic               sliceEmpty;

  cfg_loader_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .OUT_W(OUT_W), .DIV_W(DIV_W),
    .PAGES(PAGES), .OPT_WORDS(OPT_WORDS), .OPT_BASE(OPT_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pgmSel(pgmSel), .nStatus(nStatus),
    .confDone(confDone), .flashValid(flashValid), .flashData(flashData),
    .sliceEmpty(sliceEmpty), .flashReq(flashReq), .flashAddr(flashAddr),
    .dclk(dclk), .loadDone(loadDone), .cfgErr(cfgErr), .cmd(cmd), .sliceW(sliceW)
  );

  cfg_loader_dp #(
    .WORD_W(WORD_W), .OUT_W(OUT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sliceW(sliceW),
    .flashData(flashData), .cfgData(cfgData), .sliceEmpty(sliceEmpty)
  );

  // R8: data lines move only while the configuration clock is low
  a_r8_data_moves_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgData) |-> !dclk);

endmodule

// File: tb/cfg_loader_bench.sv
`timescale 1ns / 1ps
module cfg_loader_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  pgmSel = 3'd0;
  logic        nStatus = 1'b0;
  logic        confDone = 1'b0;
  logic        flashReq;
  logic [15:0] flashAddr;
  logic        flashValid = 1'b0;
  logic [15:0] flashData = 16'd0;
  logic        dclk;
  logic [7:0]  cfgData;
  logic        loadDone;
  logic        cfgErr;

  always #4 clk = ~clk;

  cfg_loader u_cfg_loader (
    .clk(clk), .rstN(rstN), .pgmSel(pgmSel), .nStatus(nStatus), .confDone(confDone),
    .flashReq(flashReq), .flashAddr(flashAddr), .flashValid(flashValid),
    .flashData(flashData), .dclk(dclk), .cfgData(cfgData), .loadDone(loadDone),
    .cfgErr(cfgErr)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [15:0] optMem [32];
  logic [15:0] addrLog [128];
  int lat = 0;
  int latCnt = 0;
  int logN = 0;

  function automatic logic [15:0] pat(input logic [15:0] a);
    logic [15:0] m;
    m = a * 16'h9E37;
    return m ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] memRead(input logic [15:0] a);
    if (a >= 16'h8000 && a < 16'h8020) return optMem[a[4:0]];
    return pat(a);
  endfunction

  always @(posedge clk) begin
    if (!rstN) logN <= 0;
    if (!rstN || !flashReq || flashValid) begin
      flashValid <= 1'b0;
      latCnt     <= 0;
    end else if (latCnt >= lat) begin
      flashValid <= 1'b1;
      flashData  <= memRead(flashAddr);
      latCnt     <= 0;
      if (logN < 128) begin
        addrLog[logN] <= flashAddr;
        logN <= logN + 1;
      end
    end else begin
      latCnt <= latCnt + 1;
    end
  end

  // ---------------- output monitor ----------------
  bit          monOn = 1'b0;
  int          sliceIdx = 0;
  int          rises = 0;
  int          highRun = 0;
  logic        prevDclk = 1'b0;
  logic [7:0]  prevData = 8'd0;
  int          curStart = 0;
  int          curLen = 0;
  int          curW = 1;
  int          curDiv = 1;
  string       curTag = "R5";

  function automatic logic [7:0] expSlice(input int k);
    int spw;
    int j;
    int s;
    logic [15:0] wd;
    spw = (16 + curW - 1) / curW;
    j = k / spw;
    s = k % spw;
    wd = pat(16'(curStart + j)) >> (s * curW);
    return wd[7:0] & 8'((1 << curW) - 1);
  endfunction

  always @(negedge clk) begin
    if (monOn) begin
      if (dclk && !prevDclk) begin
        rises++;
        check(cfgData == expSlice(sliceIdx), curTag, $sformatf("slice %0d", sliceIdx),
              cfgData, expSlice(sliceIdx));
        sliceIdx++;
        highRun = 1;
      end else if (dclk) begin
        highRun++;
      end
      if (!dclk && prevDclk && nStatus && !confDone)
        check(highRun == curDiv, "R8", "dclk high width", highRun, curDiv);
      if (dclk && prevDclk && cfgData != prevData)
        check(1'b0, "R8", "data moved while dclk high", cfgData, prevData);
    end
    prevDclk = dclk;
    prevData = cfgData;
  end

  // ---------------- helpers ----------------
  // R2 layout: word0 = mode[1:0] | div[7:4] | (chains-1)[10:8]; page p at 2+2p / 3+2p
  task automatic loadOpts(input int mode, input int chains, input int div,
                          input int pg, input int start, input int len);
    for (int i = 0; i < 32; i++) optMem[i] = 16'hC3A0 ^ 16'(i * 16'h0111);
    for (int p = 0; p < 8; p++) begin
      optMem[2 + 2 * p] = 16'(16'h6000 + p * 16'h0100);
      optMem[3 + 2 * p] = 16'(p + 2);
    end
    optMem[0] = 16'((mode & 3) | ((div & 15) << 4) | (((chains - 1) & 7) << 8));
    optMem[2 + 2 * pg] = 16'(start);
    optMem[3 + 2 * pg] = 16'(len);
  endtask

  task automatic waitDone(input int maxc);
    int t;
    t = 0;
    while (!loadDone && t < maxc) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic startRun(input int mode, input int chains, input int div, input int pg,
                          input int start, input int len, input int latency, input int pgAfter);
    bit ok;
    int t;
    int badAt;
    loadOpts(mode, chains, div, pg, start, len);
    lat      = latency;
    curStart = start;
    curLen   = len;
    curW     = (mode == 0) ? 1 : (mode == 1) ? chains : 8;
    curDiv   = (div == 0) ? 1 : div;
    curTag   = (mode == 0) ? "R5" : (mode == 1) ? "R6" : "R7";
    nStatus  = 1'b0;
    confDone = 1'b0;
    pgmSel   = 3'(pg);
    monOn    = 1'b0;
    rstN     = 1'b0;
    repeat (3) @(negedge clk);
    sliceIdx = 0;
    rises    = 0;
    monOn    = 1'b1;
    rstN     = 1'b1;
    @(negedge clk);
    pgmSel = 3'(pgAfter);  // R3: late change must be ignored
    t = 0;
    while (logN < 32 && t < 1000) begin
      @(negedge clk);
      t++;
    end
    repeat (2) @(negedge clk);
    ok = 1'b1;
    badAt = 0;
    for (int i = 0; i < 32; i++)
      if (ok && addrLog[i] != 16'(16'h8000 + i)) begin ok = 1'b0; badAt = i; end
    check(ok, "R1", "option read address", addrLog[badAt], 16'h8000 + badAt);
    check(rises == 0, "R1", "no dclk during option read", rises, 0);
    repeat (20) @(negedge clk);
    check(rises == 0 && !loadDone, "R4", "idle while nStatus low", rises, 0);
  endtask

  typedef struct packed {
    int mode; int chains; int div; int pg; int start; int len; int latency;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{0, 1, 1, 0, 16'h0200, 2, 0},
    '{0, 1, 3, 5, 16'h1234, 1, 3},
    '{1, 8, 2, 2, 16'h0400, 3, 1},
    '{1, 3, 1, 7, 16'h7FF0, 2, 2},
    '{2, 1, 0, 1, 16'h0010, 4, 0},
    '{2, 1, 5, 4, 16'hA000, 2, 6},
    '{1, 5, 2, 3, 16'h0050, 1, 0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not complete (got 0x0 expected 0x1)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int r;
    int t;
    // reset state
    repeat (3) @(negedge clk);
    check(dclk == 1'b0 && cfgData == 8'd0, "R1", "reset dclk/data idle", {dclk, cfgData}, 0);
    check(loadDone == 1'b0 && cfgErr == 1'b0, "R10", "reset flags clear", {loadDone, cfgErr}, 0);

    // table-driven runs over formats, dividers, pages and flash latencies
    for (int v = 0; v < NV; v++) begin
      startRun(VECS[v].mode, VECS[v].chains, VECS[v].div, VECS[v].pg,
               VECS[v].start, VECS[v].len, VECS[v].latency, (VECS[v].pg + 3) % 8);
      nStatus = 1'b1;
      waitDone(20000);
      repeat (2) @(negedge clk);
      check(loadDone, "R10", "done after last word", loadDone, 1);
      check(sliceIdx == VECS[v].len * ((16 + curW - 1) / curW), "R10", "slice count",
            sliceIdx, VECS[v].len * ((16 + curW - 1) / curW));
      check(addrLog[32] == 16'(VECS[v].start), "R2", "page start from options",
            addrLog[32], VECS[v].start);
      check(logN == 32 + VECS[v].len, "R3", "page length of sampled page", logN,
            32 + VECS[v].len);
      for (int j = 0; j < VECS[v].len; j++)
        check(addrLog[32 + j] == 16'(VECS[v].start + j), "R9", "sequential fetch",
              addrLog[32 + j], VECS[v].start + j);
      check(!dclk && !cfgErr, "R10", "dclk low and no fault after done", {dclk, cfgErr}, 0);
    end

    // R12: fault mid-transfer, then full replay
    startRun(0, 1, 1, 6, 16'h0300, 2, 1, 1);
    nStatus = 1'b1;
    t = 0;
    while (sliceIdx < 10 && t < 2000) begin @(negedge clk); t++; end
    nStatus = 1'b0;
    repeat (2) @(negedge clk);
    check(cfgErr, "R12", "fault flag set", cfgErr, 1);
    check(cfgData == 8'd0, "R12", "data cleared on fault", cfgData, 0);
    r = rises;
    repeat (6) @(negedge clk);
    check(rises == r && !dclk, "R12", "clock held while faulted", rises, r);
    sliceIdx = 0;
    nStatus = 1'b1;
    waitDone(20000);
    repeat (2) @(negedge clk);
    check(sliceIdx == 32, "R12", "page replayed from start", sliceIdx, 32);
    check(cfgErr, "R12", "fault flag sticky", cfgErr, 1);

    // R4 with confDone high, then R11 early stop
    startRun(2, 1, 2, 3, 16'h0800, 4, 0, 5);
    confDone = 1'b1;
    nStatus  = 1'b1;
    repeat (20) @(negedge clk);
    check(rises == 0 && !loadDone, "R4", "idle while confDone high", rises, 0);
    confDone = 1'b0;
    t = 0;
    while (sliceIdx < 3 && t < 2000) begin @(negedge clk); t++; end
    confDone = 1'b1;
    repeat (2) @(negedge clk);
    check(loadDone, "R11", "stop on confDone", loadDone, 1);
    r = rises;
    repeat (20) @(negedge clk);
    check(rises == r && !dclk, "R11", "no pulses after stop", rises, r);
    check(sliceIdx < 8, "R11", "stopped before page end", sliceIdx, 3);

    // R10: zero-length page
    startRun(1, 4, 1, 0, 16'h0900, 0, 0, 2);
    nStatus = 1'b1;
    repeat (5) @(negedge clk);
    check(loadDone, "R10", "zero length completes", loadDone, 1);
    check(rises == 0 && logN == 32, "R10", "zero length sends nothing", logN, 32);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule